// File: doc/BRIEF.md
# Interlaced Video Display Timing Generator

This block drives the raster timing of a video output that may be interlaced or progressive. A pixel counter and a line counter sweep the programmed frame. Registered flags derived from them give horizontal blanking, horizontal sync, vertical blanking, vertical sync, a field identifier and an image window. Every position is a register-style input, so software can reprogram the raster without touching the logic. Vertical events for each field take a full (line, pixel) coordinate, so a field boundary can fall in the middle of a line.

A small controller sequences the display. It has three states, named with the transitions between them:
- `ST_OFF`: output is blanked. It moves to `ST_ARM` once the blank control is released.
- `ST_ARM`: it waits for the frame origin. It moves to `ST_RUN` at pixel 0 of line 0, or back to `ST_OFF` if blanking is requested again.
- `ST_RUN`: the display is live. It returns to `ST_OFF` as soon as the blank control is raised.

While the controller is in `ST_RUN`, the end of each selected field or frame sets a done flag and the display-complete flag. An interrupt line reports the status bits that software has enabled.

In one-shot (non-continuous) mode, software must acknowledge each completion before the next one arrives. If it does not, a missed-acknowledge flag is raised.

Top module: `vid_raster_timing`

## Requirements
- R1: The pixel counter runs from 0 to `frm_w` and then returns to 0. The line counter advances on each such wrap and returns to 0 after line `frm_h`.
- R2: `hblank` rises one clock after the pixel counter equals `hb_start`. It falls one clock after the pixel counter equals `hb_stop`, and holds its value otherwise.
- R3: `hsync` is high one clock after each pixel count p with `hs_start <= p < hs_start + hs_len`.
- R4: `vblank` is set one clock after the counters reach the start point of the current field and cleared one clock after they reach its stop point. Each point is packed as {line in the upper CW bits, pixel in the lower CW bits}. Field 1 uses the `*1` inputs and field 2 uses the `*2` inputs.
- R5: `vsync` follows the same rule as R4, using the vertical sync start and stop points of the current field.
- R6: `field_id` (0 = field 1, 1 = field 2) becomes 1 one clock after the counters reach `f2_start`. It returns to 0 one clock after the frame origin (0,0).
- R7: `img_active` is high one clock after a position that lies in both of these ranges:
  - pixels from `hb_stop + img_hoff` for `img_w` pixels;
  - lines from (the current field's vertical-blank stop line + `img_voff`) for `img_h` lines.
- R8: While the controller is not in `ST_RUN`, `hblank` and `vblank` are 1, `img_active` is 0 and `disp_on` is 0. After `blank_dis` falls, `ST_RUN` begins only at the next frame origin.
- R9: In `ST_RUN`, `fld_sel` decides which done bit is set: 0 = field 1 only, 1 = field 2 only, 2 = both fields, 3 = progressive frame.
  - status[0] (field 1 done) is set at `f2_start` when `fld_sel` is 0 or 2.
  - status[1] (field 2 done) is set at (`frm_h`,`frm_w`) when `fld_sel` is 1 or 2.
  - status[2] (frame done) is set at (`frm_h`,`frm_w`) when `fld_sel` is 3.
- R10: Every done event also sets status[3] (display complete). `irq` is the OR over i of status[i] AND `int_en[i]`.
- R11: When `cont_mode` is 0 and a done event finds its done bit still set and not being cleared in that cycle, status[4] (missed acknowledge) is set. With `cont_mode` at 1, status[4] is never set.
- R12: A 1 on `stat_clr[i]` clears status[i] on the next clock. A set event in the same cycle wins over the clear.
- R13: After reset, both counters, all flags and all status bits are 0, and the controller is in `ST_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_dis | input | 1 | 1 forces blanked output; 0 allows display at the next frame |
| cont_mode | input | 1 | 1 continuous, 0 one-shot with acknowledge |
| fld_sel | input | 2 | Field select code (R9) |
| frm_w | input | CW | Last pixel index of a line |
| frm_h | input | CW | Last line index of a frame |
| hb_start | input | CW | Pixel where horizontal blanking starts |
| hb_stop | input | CW | Pixel where horizontal blanking ends |
| hs_start | input | CW | Pixel where horizontal sync starts |
| hs_len | input | CW | Horizontal sync length in pixels |
| vb_on1 | input | 2*CW | Field 1 vertical blank start {line,pixel} |
| vb_off1 | input | 2*CW | Field 1 vertical blank stop {line,pixel} |
| vb_on2 | input | 2*CW | Field 2 vertical blank start {line,pixel} |
| vb_off2 | input | 2*CW | Field 2 vertical blank stop {line,pixel} |
| vs_on1 | input | 2*CW | Field 1 vertical sync start {line,pixel} |
| vs_off1 | input | 2*CW | Field 1 vertical sync stop {line,pixel} |
| vs_on2 | input | 2*CW | Field 2 vertical sync start {line,pixel} |
| vs_off2 | input | 2*CW | Field 2 vertical sync stop {line,pixel} |
| f2_start | input | 2*CW | First {line,pixel} of field 2 |
| img_hoff | input | CW | Image horizontal offset |
| img_voff | input | CW | Image vertical offset |
| img_w | input | CW | Image width in pixels |
| img_h | input | CW | Image height in lines |
| int_en | input | 5 | Interrupt enable per status bit |
| stat_clr | input | 5 | Write-one-to-clear strobe per status bit |
| pix_cnt | output | CW | Pixel counter |
| line_cnt | output | CW | Line counter |
| hblank | output | 1 | Horizontal blanking |
| hsync | output | 1 | Horizontal sync |
| vblank | output | 1 | Vertical blanking |
| vsync | output | 1 | Vertical sync |
| field_id | output | 1 | 0 field 1, 1 field 2 |
| img_active | output | 1 | Inside the image window |
| disp_on | output | 1 | Controller in `ST_RUN` |
| status | output | 5 | {miss, complete, frame done, field 2 done, field 1 done} |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the missed-acknowledge error. It needs one-shot mode, a running display, and a second completion of the same kind arriving while the first is still unacknowledged. A clear strobe landing in the same cycle must also be told apart from a late one. The stimulus first runs continuous display without acknowledging, which must never flag an error. It then switches to one-shot mode with no clears at all, and finally walks every field-select code while pulsing clears on a fixed period that drifts against the field length. Over that walk, clears fall before, on and after completion events.

// File: rtl/vdt_pkg.sv
package vdt_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } vdt_state_e;

    localparam logic [1:0] SEL_F1   = 2'd0;
    localparam logic [1:0] SEL_F2   = 2'd1;
    localparam logic [1:0] SEL_BOTH = 2'd2;
    localparam logic [1:0] SEL_PROG = 2'd3;

    localparam int S_F1   = 0;
    localparam int S_F2   = 1;
    localparam int S_FRM  = 2;
    localparam int S_CMP  = 3;
    localparam int S_MISS = 4;
    localparam int NSTAT  = 5;
endpackage

// File: rtl/vdt_raster.sv
module vdt_raster #(
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] frm_w,
    input  logic [CW-1:0] frm_h,
    output logic [CW-1:0] pix,
    output logic [CW-1:0] line,
    output logic          at_origin,
    output logic          at_end
);
    logic line_wrap;

    assign line_wrap = (pix >= frm_w);
    assign at_origin = (pix == '0) && (line == '0);
    assign at_end    = (pix == frm_w) && (line == frm_h);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix  <= '0;
            line <= '0;
        end else begin
            pix <= line_wrap ? '0 : pix + 1'b1;
            if (line_wrap) begin
                line <= (line >= frm_h) ? '0 : line + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vdt_sync.sv
module vdt_sync #(
    parameter int CW = 11,
    localparam int PW = 2 * CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] pix,
    input  logic [CW-1:0] line,
    input  logic          at_origin,
    input  logic [CW-1:0] hb_start,
    input  logic [CW-1:0] hb_stop,
    input  logic [CW-1:0] hs_start,
    input  logic [CW-1:0] hs_len,
    input  logic [PW-1:0] vb_on1,
    input  logic [PW-1:0] vb_off1,
    input  logic [PW-1:0] vb_on2,
    input  logic [PW-1:0] vb_off2,
    input  logic [PW-1:0] vs_on1,
    input  logic [PW-1:0] vs_off1,
    input  logic [PW-1:0] vs_on2,
    input  logic [PW-1:0] vs_off2,
    input  logic [PW-1:0] f2_start,
    input  logic [CW-1:0] img_hoff,
    input  logic [CW-1:0] img_voff,
    input  logic [CW-1:0] img_w,
    input  logic [CW-1:0] img_h,
    output logic          hb_q,
    output logic          hs_q,
    output logic          vb_q,
    output logic          vs_q,
    output logic          fld_q,
    output logic          img_q
);
    logic [PW-1:0] here, vb_on, vb_off, vs_on, vs_off;
    logic [CW:0]   hs_end, x0, x1, y0, y1;
    logic          in_x, in_y;

    assign here   = {line, pix};
    assign vb_on  = fld_q ? vb_on2  : vb_on1;
    assign vb_off = fld_q ? vb_off2 : vb_off1;
    assign vs_on  = fld_q ? vs_on2  : vs_on1;
    assign vs_off = fld_q ? vs_off2 : vs_off1;

    assign hs_end = {1'b0, hs_start} + {1'b0, hs_len};
    assign x0     = {1'b0, hb_stop} + {1'b0, img_hoff};
    assign x1     = x0 + {1'b0, img_w};
    assign y0     = {1'b0, vb_off[PW-1:CW]} + {1'b0, img_voff};
    assign y1     = y0 + {1'b0, img_h};
    assign in_x   = ({1'b0, pix} >= x0) && ({1'b0, pix} < x1);
    assign in_y   = ({1'b0, line} >= y0) && ({1'b0, line} < y1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hb_q  <= 1'b0;
            hs_q  <= 1'b0;
            vb_q  <= 1'b0;
            vs_q  <= 1'b0;
            fld_q <= 1'b0;
            img_q <= 1'b0;
        end else begin
            if (pix == hb_start)     hb_q <= 1'b1;
            else if (pix == hb_stop) hb_q <= 1'b0;

            hs_q <= ({1'b0, pix} >= {1'b0, hs_start}) && ({1'b0, pix} < hs_end);

            if (here == vb_on)       vb_q <= 1'b1;
            else if (here == vb_off) vb_q <= 1'b0;

            if (here == vs_on)       vs_q <= 1'b1;
            else if (here == vs_off) vs_q <= 1'b0;

            if (here == f2_start)    fld_q <= 1'b1;
            else if (at_origin)      fld_q <= 1'b0;

            img_q <= in_x && in_y;
        end
    end
endmodule

// File: rtl/vdt_ctrl.sv
module vdt_ctrl
    import vdt_pkg::*;
#(
    parameter int CW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank_dis,
    input  logic             cont_mode,
    input  logic [1:0]       fld_sel,
    input  logic             at_origin,
    input  logic             at_end,
    input  logic             at_f2,
    input  logic [NSTAT-1:0] int_en,
    input  logic [NSTAT-1:0] stat_clr,
    output logic             running,
    output logic [NSTAT-1:0] status,
    output logic             irq
);
    vdt_state_e      state, state_nx;
    logic [2:0]      ev;
    logic            miss;
    logic [NSTAT-1:0] kept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: if (!blank_dis) state_nx = ST_ARM;
            ST_ARM: begin
                if (blank_dis)      state_nx = ST_OFF;
                else if (at_origin) state_nx = ST_RUN;
            end
            ST_RUN: if (blank_dis)  state_nx = ST_OFF;
            default:                state_nx = ST_OFF;
        endcase
    end

    // completion events and status outputs
    assign running = (state == ST_RUN);
    always_comb begin
        ev[S_F1]  = running && at_f2  && (fld_sel == SEL_F1 || fld_sel == SEL_BOTH);
        ev[S_F2]  = running && at_end && (fld_sel == SEL_F2 || fld_sel == SEL_BOTH);
        ev[S_FRM] = running && at_end && (fld_sel == SEL_PROG);
        miss      = !cont_mode && |(ev & status[2:0] & ~stat_clr[2:0]);
        kept      = status & ~stat_clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status[2:0]    <= kept[2:0] | ev;
            status[S_CMP]  <= kept[S_CMP] | (|ev);
            status[S_MISS] <= kept[S_MISS] | miss;
        end
    end

    assign irq = |(status & int_en);
endmodule

// File: rtl/vid_raster_timing.sv
module vid_raster_timing
    import vdt_pkg::*;
#(
    parameter int CW = 11,
    localparam int PW = 2 * CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank_dis,
    input  logic             cont_mode,
    input  logic [1:0]       fld_sel,
    input  logic [CW-1:0]    frm_w,
    input  logic [CW-1:0]    frm_h,
    input  logic [CW-1:0]    hb_start,
    input  logic [CW-1:0]    hb_stop,
    input  logic [CW-1:0]    hs_start,
    input  logic [CW-1:0]    hs_len,
    input  logic [PW-1:0]    vb_on1,
    input  logic [PW-1:0]    vb_off1,
    input  logic [PW-1:0]    vb_on2,
    input  logic [PW-1:0]    vb_off2,
    input  logic [PW-1:0]    vs_on1,
    input  logic [PW-1:0]    vs_off1,
    input  logic [PW-1:0]    vs_on2,
    input  logic [PW-1:0]    vs_off2,
    input  logic [PW-1:0]    f2_start,
    input  logic [CW-1:0]    img_hoff,
    input  logic [CW-1:0]    img_voff,
    input  logic [CW-1:0]    img_w,
    input  logic [CW-1:0]    img_h,
    input  logic [NSTAT-1:0] int_en,
    input  logic [NSTAT-1:0] stat_clr,
    output logic [CW-1:0]    pix_cnt,
    output logic [CW-1:0]    line_cnt,
    output logic             hblank,
    output logic             hsync,
    output logic             vblank,
    output logic             vsync,
    output logic             field_id,
    output logic             img_active,
    output logic             disp_on,
    output logic [NSTAT-1:0] status,
    output logic             irq
);
    logic at_origin, at_end, at_f2;
    logic hb_q, vb_q, img_q;

    vdt_raster #(.CW(CW)) u_raster (
        .clk(clk), .rst_n(rst_n), .frm_w(frm_w), .frm_h(frm_h),
        .pix(pix_cnt), .line(line_cnt), .at_origin(at_origin), .at_end(at_end)
    );

    assign at_f2 = ({line_cnt, pix_cnt} == f2_start);

    vdt_sync #(.CW(CW)) u_sync (
        .clk(clk), .rst_n(rst_n), .pix(pix_cnt), .line(line_cnt), .at_origin(at_origin),
        .hb_start(hb_start), .hb_stop(hb_stop), .hs_start(hs_start), .hs_len(hs_len),
        .vb_on1(vb_on1), .vb_off1(vb_off1), .vb_on2(vb_on2), .vb_off2(vb_off2),
        .vs_on1(vs_on1), .vs_off1(vs_off1), .vs_on2(vs_on2), .vs_off2(vs_off2),
        .f2_start(f2_start), .img_hoff(img_hoff), .img_voff(img_voff),
        .img_w(img_w), .img_h(img_h),
        .hb_q(hb_q), .hs_q(hsync), .vb_q(vb_q), .vs_q(vsync), .fld_q(field_id), .img_q(img_q)
    );

    vdt_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .blank_dis(blank_dis), .cont_mode(cont_mode),
        .fld_sel(fld_sel), .at_origin(at_origin), .at_end(at_end), .at_f2(at_f2),
        .int_en(int_en), .stat_clr(stat_clr), .running(disp_on), .status(status), .irq(irq)
    );

    assign hblank     = hb_q | ~disp_on;
    assign vblank     = vb_q | ~disp_on;
    assign img_active = img_q & disp_on;
endmodule

// File: rtl/vdt_checker.sv
module vdt_checker #(
    parameter int CW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] pix_cnt,
    input logic [CW-1:0] line_cnt,
    input logic [CW-1:0] frm_w,
    input logic [CW-1:0] hb_start,
    input logic [CW-1:0] hb_stop,
    input logic [CW-1:0] hs_start,
    input logic [CW-1:0] hs_len,
    input logic          cont_mode,
    input logic          disp_on,
    input logic          hblank,
    input logic          hsync,
    input logic [4:0]    status
);
    // R1: the pixel counter wraps after the last pixel
    a_r1_pix_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt == frm_w) |=> (pix_cnt == '0));

    // R1: the line counter only moves on a wrap
    a_r1_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt < frm_w) |=> $stable(line_cnt));

    // R2: blanking follows the start pixel
    a_r2_hblank_on: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt == hb_start && hb_start != hb_stop) |=> hblank);

    // R3: sync follows the start pixel
    a_r3_hsync_on: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt == hs_start && hs_len != '0) |=> hsync);

    // R8: display goes live only from the frame origin
    a_r8_start_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disp_on) |-> ($past(pix_cnt) == '0 && $past(line_cnt) == '0));

    // R9: no done bit becomes set while the display is idle
    a_r9_idle_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> ((status[2:0] & ~$past(status[2:0])) == 3'b000));

    // R11: the missed-acknowledge flag rises only in one-shot mode
    a_r11_miss_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> !$past(cont_mode));
endmodule

bind vid_raster_timing vdt_checker #(.CW(CW)) u_vdt_checker (
    .clk(clk), .rst_n(rst_n), .pix_cnt(pix_cnt), .line_cnt(line_cnt), .frm_w(frm_w),
    .hb_start(hb_start), .hb_stop(hb_stop), .hs_start(hs_start), .hs_len(hs_len),
    .cont_mode(cont_mode), .disp_on(disp_on), .hblank(hblank), .hsync(hsync),
    .status(status)
);

// File: tb/test_vid_raster_timing.sv
module test_vid_raster_timing;
    localparam int CW = 11;
    localparam int PW = 2 * CW;
    localparam int W = 19, H = 9;
    localparam int HB_ON = 16, HB_OFF = 2, HS_AT = 17, HS_LEN = 2;
    localparam int F2L = 5, F2P = 10;
    localparam int HOFF = 1, VOFF = 1, IW = 10, IH = 2;
    localparam int VBN_L[2] = '{0, 5};
    localparam int VBN_P[2] = '{3, 12};
    localparam int VBF_L[2] = '{1, 6};
    localparam int VBF_P[2] = '{4, 0};
    localparam int VSN_L[2] = '{0, 5};
    localparam int VSN_P[2] = '{5, 14};
    localparam int VSF_L[2] = '{0, 6};
    localparam int VSF_P[2] = '{15, 4};

    logic clk = 1'b0, rst_n = 1'b0;
    logic blank_dis = 1'b1, cont_mode = 1'b1;
    logic [1:0] fld_sel = 2'd2;
    logic [4:0] int_en = 5'b10000, stat_clr = 5'b0;
    logic [CW-1:0] pix_cnt, line_cnt;
    logic hblank, hsync, vblank, vsync, field_id, img_active, disp_on, irq;
    logic [4:0] status;

    int n_chk = 0, n_fail = 0;
    bit started = 0, finished = 0;

    always #10 clk = ~clk;

    function automatic logic [PW-1:0] pos(input int l, input int p);
        return {l[CW-1:0], p[CW-1:0]};
    endfunction

    vid_raster_timing #(.CW(CW)) i_vid_raster_timing (
        .clk(clk), .rst_n(rst_n), .blank_dis(blank_dis), .cont_mode(cont_mode),
        .fld_sel(fld_sel), .frm_w(CW'(W)), .frm_h(CW'(H)),
        .hb_start(CW'(HB_ON)), .hb_stop(CW'(HB_OFF)), .hs_start(CW'(HS_AT)), .hs_len(CW'(HS_LEN)),
        .vb_on1(pos(VBN_L[0], VBN_P[0])), .vb_off1(pos(VBF_L[0], VBF_P[0])),
        .vb_on2(pos(VBN_L[1], VBN_P[1])), .vb_off2(pos(VBF_L[1], VBF_P[1])),
        .vs_on1(pos(VSN_L[0], VSN_P[0])), .vs_off1(pos(VSF_L[0], VSF_P[0])),
        .vs_on2(pos(VSN_L[1], VSN_P[1])), .vs_off2(pos(VSF_L[1], VSF_P[1])),
        .f2_start(pos(F2L, F2P)), .img_hoff(CW'(HOFF)), .img_voff(CW'(VOFF)),
        .img_w(CW'(IW)), .img_h(CW'(IH)), .int_en(int_en), .stat_clr(stat_clr),
        .pix_cnt(pix_cnt), .line_cnt(line_cnt), .hblank(hblank), .hsync(hsync),
        .vblank(vblank), .vsync(vsync), .field_id(field_id), .img_active(img_active),
        .disp_on(disp_on), .status(status), .irq(irq)
    );

    // behavioural reference
    int m_pix, m_line, m_hb, m_hs, m_vb, m_vs, m_fld, m_img, m_state;
    logic [4:0] m_st;

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_pix = 0; m_line = 0; m_hb = 0; m_hs = 0; m_vb = 0; m_vs = 0;
            m_fld = 0; m_img = 0; m_state = 0; m_st = 5'b0;
        end else begin
            int f, base, n_hb, n_vb, n_vs, n_fld, n_state;
            bit h_f2, fend, run, miss;
            logic [2:0] ev;
            logic [4:0] n_st;
            f     = m_fld;
            h_f2  = (m_line == F2L && m_pix == F2P);
            fend  = (m_line == H && m_pix == W);
            run   = (m_state == 2);
            n_hb  = (m_pix == HB_ON) ? 1 : (m_pix == HB_OFF) ? 0 : m_hb;
            n_vb  = (m_line == VBN_L[f] && m_pix == VBN_P[f]) ? 1 :
                    (m_line == VBF_L[f] && m_pix == VBF_P[f]) ? 0 : m_vb;
            n_vs  = (m_line == VSN_L[f] && m_pix == VSN_P[f]) ? 1 :
                    (m_line == VSF_L[f] && m_pix == VSF_P[f]) ? 0 : m_vs;
            n_fld = h_f2 ? 1 : (m_pix == 0 && m_line == 0) ? 0 : m_fld;
            base  = VBF_L[f] + VOFF;
            m_img = (m_pix >= HB_OFF + HOFF && m_pix < HB_OFF + HOFF + IW &&
                     m_line >= base && m_line < base + IH) ? 1 : 0;
            m_hs  = (m_pix >= HS_AT && m_pix < HS_AT + HS_LEN) ? 1 : 0;
            ev[0] = run && h_f2 && (fld_sel == 0 || fld_sel == 2);
            ev[1] = run && fend && (fld_sel == 1 || fld_sel == 2);
            ev[2] = run && fend && (fld_sel == 3);
            miss  = !cont_mode && ((ev & m_st[2:0] & ~stat_clr[2:0]) != 3'b0);
            n_st  = m_st & ~stat_clr;
            n_st[2:0] = n_st[2:0] | ev;
            if (ev != 3'b0) n_st[3] = 1'b1;
            if (miss)       n_st[4] = 1'b1;
            n_state = m_state;
            if (m_state == 0 && !blank_dis) n_state = 1;
            else if (m_state == 1) n_state = blank_dis ? 0 : (m_pix == 0 && m_line == 0) ? 2 : 1;
            else if (m_state == 2 && blank_dis) n_state = 0;
            if (m_pix >= W) begin
                m_pix = 0;
                m_line = (m_line >= H) ? 0 : m_line + 1;
            end else m_pix = m_pix + 1;
            m_hb = n_hb; m_vb = n_vb; m_vs = n_vs; m_fld = n_fld;
            m_st = n_st; m_state = n_state;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            bit on;
            on = (m_state == 2);
            chk("R1 pixel", int'(pix_cnt), m_pix);
            chk("R1 line", int'(line_cnt), m_line);
            chk("R2 hblank", int'(hblank), (m_hb != 0 || !on) ? 1 : 0);
            chk("R3 hsync", int'(hsync), m_hs);
            chk("R4 vblank", int'(vblank), (m_vb != 0 || !on) ? 1 : 0);
            chk("R5 vsync", int'(vsync), m_vs);
            chk("R6 field", int'(field_id), m_fld);
            chk("R7 image", int'(img_active), (m_img != 0 && on) ? 1 : 0);
            chk("R8 disp_on", int'(disp_on), on ? 1 : 0);
            chk("R9 done bits", int'(status[2:0]), int'(m_st[2:0]));
            chk("R10 complete", int'(status[3]), int'(m_st[3]));
            chk("R10 irq", int'(irq), ((m_st & int_en) != 5'b0) ? 1 : 0);
            chk("R11 miss", int'(status[4]), int'(m_st[4]));
        end
    end

    task automatic clear_all();
        @(negedge clk); stat_clr = 5'h1F;
        @(negedge clk); stat_clr = 5'h00;
        chk("R12 cleared", int'(status), int'(m_st));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R13 reset state", int'({pix_cnt, line_cnt, status, disp_on}), 0);
        rst_n = 1'b1;
        repeat (450) @(negedge clk);
        chk("R8 blanked while disabled", int'(disp_on), 0);
        blank_dis = 1'b0;                       // mid-frame release
        repeat (700) @(negedge clk);
        chk("R11 continuous never misses", int'(status[4]), 0);
        chk("R10 complete masked", int'(irq), 0);
        int_en = 5'h1F;
        clear_all();
        repeat (400) @(negedge clk);
        cont_mode = 1'b0;
        clear_all();
        repeat (600) @(negedge clk);
        chk("R11 one-shot miss raised", int'(status[4]), 1);
        for (int s = 0; s < 4; s++) begin
            fld_sel = 2'(s);
            clear_all();
            for (int k = 0; k < 7; k++) begin
                repeat (93) @(negedge clk);
                clear_all();
            end
        end
        blank_dis = 1'b1;
        repeat (300) @(negedge clk);
        chk("R8 blanked again", int'(disp_on), 0);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule